// File: doc/BRIEF.md
# Composite Memory Select Generator

This block forms one extra chip-select, the composite select, from the four per-space memory selects: program, data, byte and I/O. Each space has an enable bit in a control register. The composite output goes low in the same cycle as any enabled space select, so it keeps the timing of the select it follows. One memory can therefore answer in several spaces. For example, a single RAM can serve as both program and data store, and one of the individual selects then acts as an extra address bit.

A separate system register holds a byte-select disable bit. This bit silences the dedicated byte-select output but leaves the composite path alone. At reset the byte select drives a boot memory, and the composite select ignores byte accesses. After boot, software can disable the byte output and enable the byte bit of the composite mask. A second memory on the composite pin then takes over byte space.

A two-state bus ownership machine shares the bus with an external master. In `BUS_LOCAL` the block drives its selects. The transition `LOCAL_TO_RELEASED` fires on the clock edge where a bus request is present and every incoming select is inactive. In `BUS_RELEASED` the grant output is high and every select output, the composite included, is held inactive. The transition `RELEASED_TO_LOCAL` fires on the first edge after the request drops.

Top module: `cmsg_top`

## Requirements
- R1: After reset, the control register at address 0x3FE6 reads 0x0B00 and the system register at address 0x3FFF reads 0x0000. Bus grant is low and all select outputs are high.
- R2: While the bus is held locally, `cms_out_n` is low in the same cycle in which at least one space select is low and enabled in the mask. Otherwise it is high.
- R3: The mask occupies bits 11..8 of the control register: bit 8 enables program, bit 9 data, bit 10 byte and bit 11 I/O. A write takes effect from the following cycle and reads back unchanged.
- R4: Register bits outside the mask field and outside the disable bit always read 0, whatever was written to them.
- R5: Bit 3 of the system register disables the byte output. While it is 1, `bm_out_n` stays high. While it is 0, `bm_out_n` follows `bm_sel_n`.
- R6: The byte-disable bit has no effect on the composite path. A byte access with mask bit 10 set drives `cms_out_n` low even while the byte output is disabled.
- R7: A bus request is granted on the first rising edge at which `bus_req` is high and all four incoming selects are high. While any select is low, the grant is withheld.
- R8: While `bus_grant` is high, all five select outputs are high, whatever the inputs and the mask hold.
- R9: `bus_grant` falls on the first rising edge at which `bus_req` is low.
- R10: A write to any address other than 0x3FE6 or 0x3FFF changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 14 | Register address, used for both read and write |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` (combinational) |
| pm_sel_n | input | 1 | Program-space select from the decoder, active low |
| dm_sel_n | input | 1 | Data-space select from the decoder, active low |
| bm_sel_n | input | 1 | Byte-space select from the decoder, active low |
| io_sel_n | input | 1 | I/O-space select from the decoder, active low |
| bus_req | input | 1 | External master requests the bus |
| bus_grant | output | 1 | Bus is released to the external master |
| pm_out_n | output | 1 | Program select output, active low |
| dm_out_n | output | 1 | Data select output, active low |
| bm_out_n | output | 1 | Byte select output, active low |
| io_out_n | output | 1 | I/O select output, active low |
| cms_out_n | output | 1 | Composite select output, active low |

## Verification
The bench builds the block with its default parameters. These are a 14-bit register address, 16-bit data, the mask at bits 11..8 and the byte-disable bit at bit 3. The two register addresses are therefore near the top of the address range, and random writes to other addresses can fall on neighbours that differ in a single bit. With four spaces, the bench reaches all 16 mask values and all 16 select-input patterns within a short run of random stimulus. The directed cases then cover the byte hand-over and the bus grant handshake.

// File: rtl/cmsg_pkg.sv
package cmsg_pkg;

    localparam int NUM_SPACES = 4;

    // Index of each space in the select and mask vectors.
    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_BYTE = 2'd2,
        SP_IO   = 2'd3
    } space_e;

    typedef enum logic {
        BUS_LOCAL    = 1'b0,
        BUS_RELEASED = 1'b1
    } bus_state_e;

    // Every space is enabled at reset except byte.
    localparam logic [NUM_SPACES-1:0] MASK_RESET = 4'b1011;

endpackage

// File: rtl/cmsg_regs.sv
module cmsg_regs #(
    parameter int ADDR_W    = 14,
    parameter int DATA_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FE6,
    parameter logic [ADDR_W-1:0] SYS_ADDR  = 14'h3FFF,
    parameter int MASK_LSB  = 8,
    parameter int BDIS_BIT  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr_en,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic [cmsg_pkg::NUM_SPACES-1:0] mask,
    output logic                            byte_dis
);
    localparam int NS = cmsg_pkg::NUM_SPACES;

    logic [NS-1:0] mask_q;
    logic          bdis_q;
    logic          hit_ctrl;
    logic          hit_sys;

    assign hit_ctrl = (addr == CTRL_ADDR);
    assign hit_sys  = (addr == SYS_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= cmsg_pkg::MASK_RESET;
            bdis_q <= 1'b0;
        end else if (wr_en) begin
            if (hit_ctrl) mask_q <= wdata[MASK_LSB +: NS];
            if (hit_sys)  bdis_q <= wdata[BDIS_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[MASK_LSB +: NS] = mask_q;
        end else if (hit_sys) begin
            rdata[BDIS_BIT] = bdis_q;
        end
    end

    assign mask     = mask_q;
    assign byte_dis = bdis_q;

    // R10: a write elsewhere leaves both registers unchanged
    p_write_isolation_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_ctrl && !hit_sys) |=> ($stable(mask_q) && $stable(bdis_q)));

    // R3: a write to the control address lands in the mask
    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctrl) |=> (mask_q == $past(wdata[MASK_LSB +: NS])));

endmodule

// File: rtl/cmsg_bus_fsm.sv
module cmsg_bus_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic sel_idle,
    output logic granted
);
    import cmsg_pkg::*;

    bus_state_e state_q;
    bus_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_LOCAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_LOCAL:    if (bus_req && sel_idle) state_d = BUS_RELEASED;
            BUS_RELEASED: if (!bus_req)            state_d = BUS_LOCAL;
            default:                               state_d = BUS_LOCAL;
        endcase
    end

    always_comb begin
        granted = 1'b0;
        unique case (state_q)
            BUS_LOCAL:    granted = 1'b0;
            BUS_RELEASED: granted = 1'b1;
            default:      granted = 1'b0;
        endcase
    end

    // R7: the grant rises only after an edge with a request and idle selects
    p_grant_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted) |-> $past(bus_req && sel_idle));

    // R9: the grant falls the edge after the request drops
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && !bus_req) |=> !granted);

endmodule

// File: rtl/cmsg_combine.sv
module cmsg_combine (
    input  logic [cmsg_pkg::NUM_SPACES-1:0] sel_n,
    input  logic [cmsg_pkg::NUM_SPACES-1:0] mask,
    input  logic                            byte_dis,
    input  logic                            granted,
    output logic [cmsg_pkg::NUM_SPACES-1:0] sel_out_n,
    output logic                            cms_n
);
    import cmsg_pkg::*;

    localparam int NS = NUM_SPACES;

    logic [NS-1:0] hit;

    for (genvar g = 0; g < NS; g++) begin : g_space
        if (g == int'(SP_BYTE)) begin : g_byte
            assign sel_out_n[g] = sel_n[g] | granted | byte_dis;
        end else begin : g_plain
            assign sel_out_n[g] = sel_n[g] | granted;
        end
        assign hit[g] = mask[g] & ~sel_n[g];
    end

    assign cms_n = granted | ~(|hit);

endmodule

// File: rtl/cmsg_top.sv
module cmsg_top #(
    parameter int ADDR_W   = 14,
    parameter int DATA_W   = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FE6,
    parameter logic [ADDR_W-1:0] SYS_ADDR  = 14'h3FFF,
    parameter int MASK_LSB = 8,
    parameter int BDIS_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              pm_sel_n,
    input  logic              dm_sel_n,
    input  logic              bm_sel_n,
    input  logic              io_sel_n,
    input  logic              bus_req,
    output logic              bus_grant,
    output logic              pm_out_n,
    output logic              dm_out_n,
    output logic              bm_out_n,
    output logic              io_out_n,
    output logic              cms_out_n
);
    import cmsg_pkg::*;

    localparam int NS = NUM_SPACES;

    logic [NS-1:0] sel_in_n;
    logic [NS-1:0] sel_out_n;
    logic [NS-1:0] mask;
    logic          byte_dis;
    logic          granted;

    assign sel_in_n[SP_PROG] = pm_sel_n;
    assign sel_in_n[SP_DATA] = dm_sel_n;
    assign sel_in_n[SP_BYTE] = bm_sel_n;
    assign sel_in_n[SP_IO]   = io_sel_n;

    cmsg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
        .SYS_ADDR(SYS_ADDR), .MASK_LSB(MASK_LSB), .BDIS_BIT(BDIS_BIT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wr_en(cfg_wr_en),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .mask(mask), .byte_dis(byte_dis)
    );

    cmsg_bus_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
        .sel_idle(&sel_in_n), .granted(granted)
    );

    cmsg_combine comb_i (
        .sel_n(sel_in_n), .mask(mask), .byte_dis(byte_dis),
        .granted(granted), .sel_out_n(sel_out_n), .cms_n(cms_out_n)
    );

    assign pm_out_n  = sel_out_n[SP_PROG];
    assign dm_out_n  = sel_out_n[SP_DATA];
    assign bm_out_n  = sel_out_n[SP_BYTE];
    assign io_out_n  = sel_out_n[SP_IO];
    assign bus_grant = granted;

    // R8: nothing is selected while the bus is released
    p_granted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> (cms_out_n && pm_out_n && dm_out_n && bm_out_n && io_out_n));

    // R5: a disabled byte output never goes low
    p_byte_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_dis |-> bm_out_n);

    // R2: the composite goes low only while some enabled space is selected
    p_cms_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cms_out_n |-> ((mask & ~sel_in_n) != '0));

endmodule

// File: tb/cmsg_top_tb_top.sv
module cmsg_top_tb_top;

    localparam logic [13:0] A_CTRL = 14'h3FE6;
    localparam logic [13:0] A_SYS  = 14'h3FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cfg_addr = '0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        pm_sel_n = 1'b1, dm_sel_n = 1'b1, bm_sel_n = 1'b1, io_sel_n = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_grant, pm_out_n, dm_out_n, bm_out_n, io_out_n, cms_out_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0] m_mask = 4'b1011;   // model: {io, byte, data, prog}
    logic       m_bdis = 1'b0;

    always #5 clk = ~clk;

    cmsg_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr_en(cfg_wr_en),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pm_sel_n(pm_sel_n), .dm_sel_n(dm_sel_n), .bm_sel_n(bm_sel_n), .io_sel_n(io_sel_n),
        .bus_req(bus_req), .bus_grant(bus_grant),
        .pm_out_n(pm_out_n), .dm_out_n(dm_out_n), .bm_out_n(bm_out_n), .io_out_n(io_out_n),
        .cms_out_n(cms_out_n)
    );

    function automatic logic exp_cms(logic [3:0] mk, logic [3:0] sn, logic gr);
        return gr | ~(|(mk & ~sn));
    endfunction

    function automatic logic [15:0] exp_rd(logic [13:0] a);
        if (a == A_CTRL) return {4'b0, m_mask, 8'b0};
        if (a == A_SYS)  return {12'b0, m_bdis, 3'b0};
        return 16'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_sel(input logic [3:0] sn);
        {io_sel_n, bm_sel_n, dm_sel_n, pm_sel_n} = sn;
    endtask

    // Drives selects at the falling edge and checks all outputs combinationally.
    task automatic apply_check(input logic [3:0] sn, input string req);
        @(negedge clk);
        set_sel(sn);
        #1;
        check(req, {27'b0, cms_out_n, io_out_n, bm_out_n, dm_out_n, pm_out_n},
              {27'b0, exp_cms(m_mask, sn, 1'b0), sn[3], sn[2] | m_bdis, sn[1], sn[0]});
    endtask

    task automatic write_reg(input logic [13:0] a, input logic [15:0] d);
        @(negedge clk);
        set_sel(4'hF);
        cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a == A_CTRL) m_mask = d[11:8];
        if (a == A_SYS)  m_bdis = d[3];
    endtask

    task automatic read_check(input logic [13:0] a, input string req);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, {16'b0, cfg_rdata}, {16'b0, exp_rd(a)});
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [13:0] ra;
        void'($urandom(32'h5EED_0C35));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check(A_CTRL, "R1");
        read_check(A_SYS, "R1");
        check("R1", {31'b0, bus_grant}, 32'd0);
        check("R1", {27'b0, cms_out_n, io_out_n, bm_out_n, dm_out_n, pm_out_n}, 32'h1F);

        // R2 with the reset mask: byte is not part of the composite
        apply_check(4'b1110, "R2");
        apply_check(4'b1101, "R2");
        apply_check(4'b0111, "R2");
        apply_check(4'b1011, "R2");

        // R3 / R4 mask field and reserved bits
        write_reg(A_CTRL, 16'hFFFF);
        read_check(A_CTRL, "R4");
        write_reg(A_CTRL, 16'h0400);
        read_check(A_CTRL, "R3");
        apply_check(4'b1110, "R3");
        apply_check(4'b1011, "R3");

        // R5 / R6 byte disable keeps the composite working
        write_reg(A_SYS, 16'hFFFF);
        read_check(A_SYS, "R4");
        apply_check(4'b1011, "R6");
        check("R5", {31'b0, bm_out_n}, 32'd1);
        write_reg(A_SYS, 16'h0000);
        apply_check(4'b1011, "R5");
        check("R5", {31'b0, bm_out_n}, 32'd0);
        write_reg(A_SYS, 16'h0008);

        // R10 other addresses leave both registers alone
        write_reg(14'h3FE7, 16'h0000);
        write_reg(14'h3FFE, 16'h0000);
        read_check(A_CTRL, "R10");
        read_check(A_SYS, "R10");

        // R7 grant held off while a select is active
        write_reg(A_CTRL, 16'h0F00);
        @(negedge clk);
        set_sel(4'b1110);
        bus_req = 1'b1;
        @(negedge clk);
        check("R7", {31'b0, bus_grant}, 32'd0);
        set_sel(4'hF);
        @(negedge clk);
        check("R7", {31'b0, bus_grant}, 32'd1);

        // R8 all outputs quiet while granted
        set_sel(4'h0);
        #1;
        check("R8", {27'b0, cms_out_n, io_out_n, bm_out_n, dm_out_n, pm_out_n}, 32'h1F);

        // R9 release
        @(negedge clk);
        set_sel(4'hF);
        bus_req = 1'b0;
        @(negedge clk);
        check("R9", {31'b0, bus_grant}, 32'd0);

        // Random mix of register writes and select patterns (R2, R3, R5, R10)
        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = $urandom_range(0, 5);
            if (kind == 0) write_reg(A_CTRL, 16'($urandom));
            else if (kind == 1) write_reg(A_SYS, 16'($urandom));
            else if (kind == 2) begin
                ra = 14'($urandom);
                if (ra == A_CTRL || ra == A_SYS) ra = 14'h0100;
                write_reg(ra, 16'($urandom));
                read_check(A_CTRL, "R10");
                read_check(A_SYS, "R10");
            end else begin
                apply_check(4'($urandom), "R2");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule